// File: doc/BRIEF.md
# Execution-Count Break Trigger

This block sits behind the address and data comparators of a debug unit. It lets a break request through only after the compare condition has been seen a programmed number of times. Software loads a 12-bit occurrence count through a 16-bit register port. While count mode is on, each single-cycle match pulse lowers the count by one. The match that arrives while the count already reads 1 raises a single-cycle break request toward the CPU. The count is left at 1 after that match, so a later match fires again.

When count mode is off, every match raises the break request and the count is not touched. A count of 0 with count mode on behaves the same way: each match fires at once. The register read port always shows the live count in its low twelve bits. The upper four bits read as zero.

Top module: `exec_count_brk`

## Requirements
- R1: After synchronous reset the count is 0, `brk_o` is low and `rdata` reads 0x0000.
- R2: A write with `wr_en` high loads `wdata[11:0]` into the count. From the next cycle `rdata[11:0]` shows it and `rdata[15:12]` reads 0 whatever was written there.
- R3: With `cnt_en` high, a match while the count is 2 or more lowers the count by exactly 1 and raises no break.
- R4: With `cnt_en` high, a match while the count is 1 raises a break, and the count stays at 1.
- R5: With `cnt_en` high, a match while the count is 0 raises a break, and the count stays at 0.
- R6: With `cnt_en` low, every match raises a break and the count is unchanged.
- R7: A write in the same cycle as a match wins over the decrement: the count takes the written value. Whether that match breaks is decided from the count held before the write.
- R8: `brk_o` is high for exactly the one cycle after a breaking match. It is never high in a cycle that does not follow a match.
- R9: The largest count is 4095. Writing 0xFFFF reads back 0x0FFF, and the break then comes on the 4095th match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count mode enable |
| match_i | input | 1 | Single-cycle compare-matched pulse |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 16 | Register write data |
| rdata | output | 16 | Register read data: zero-padded count |
| brk_o | output | 1 | Single-cycle break request |

## Verification
The two functions that can land in one cycle are a software write and a count decrement triggered by a match. The bench provokes this by asserting `wr_en` together with `match_i`, both with a count above 1 and with the count at 1. It then judges the following cycle against two expectations. The read-back count must equal the written value, not the decremented one. The break request must follow the count as it stood before the write, so it stays low in the first case and fires in the second.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_DEC  = 2'd2
  } cnt_act_e;
endpackage

// File: rtl/ecb_fire_logic.sv
module ecb_fire_logic
  import ecb_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             match_i,
  input  logic             cnt_en,
  input  logic             wr_en,
  output cnt_act_e         act,
  output logic             fire
);
  // count of 0 or 1: the terminal region
  logic at_floor;

  always_comb begin
    at_floor = (cnt[CNT_W-1:1] == '0);
    fire     = match_i && (!cnt_en || at_floor);
    if (wr_en)
      act = ACT_LOAD;
    else if (match_i && cnt_en && !at_floor)
      act = ACT_DEC;
    else
      act = ACT_HOLD;
  end
endmodule

// File: rtl/ecb_count_reg.sv
module ecb_count_reg
  import ecb_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_act_e         act,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      unique case (act)
        ACT_LOAD: cnt_q <= load_val;
        ACT_DEC:  cnt_q <= cnt_q - CNT_W'(1);
        default:  cnt_q <= cnt_q;
      endcase
    end
  end

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    act == ACT_DEC |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    act == ACT_LOAD |=> cnt_q == $past(load_val));
endmodule

// File: rtl/ecb_brk_pulse.sv
module ecb_brk_pulse (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic brk_q
);
  always_ff @(posedge clk) begin
    if (rst) brk_q <= 1'b0;
    else     brk_q <= fire;
  end
endmodule

// File: rtl/exec_count_brk.sv
module exec_count_brk
  import ecb_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             match_i,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             brk_o
);
  localparam int PAD_W = REG_W - CNT_W;

  cnt_act_e         act;
  logic             fire;
  logic [CNT_W-1:0] cnt_q;

  ecb_fire_logic #(.CNT_W(CNT_W)) i_fire (
    .cnt     (cnt_q),
    .match_i (match_i),
    .cnt_en  (cnt_en),
    .wr_en   (wr_en),
    .act     (act),
    .fire    (fire)
  );

  ecb_count_reg #(.CNT_W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst      (rst),
    .act      (act),
    .load_val (wdata[CNT_W-1:0]),
    .cnt_q    (cnt_q)
  );

  ecb_brk_pulse i_pulse (
    .clk   (clk),
    .rst   (rst),
    .fire  (fire),
    .brk_q (brk_o)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign rdata = {{PAD_W{1'b0}}, cnt_q};
    end else begin : g_nopad
      assign rdata = cnt_q[REG_W-1:0];
    end
  endgenerate

  // R8
  brk_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
    brk_o |-> $past(match_i));

  // R4
  hold_at_one_chk: assert property (@(posedge clk) disable iff (rst)
    (match_i && cnt_en && !wr_en && cnt_q == CNT_W'(1))
      |=> (brk_o && cnt_q == CNT_W'(1)));

  // R5
  zero_fires_chk: assert property (@(posedge clk) disable iff (rst)
    (match_i && cnt_en && !wr_en && cnt_q == '0) |=> (brk_o && cnt_q == '0));

  // R6
  mode_off_chk: assert property (@(posedge clk) disable iff (rst)
    (match_i && !cnt_en && !wr_en) |=> (brk_o && $stable(cnt_q)));

  // R7
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && match_i) |=> cnt_q == $past(wdata[CNT_W-1:0]));
endmodule

// File: tb/test_exec_count_brk.sv
`timescale 1ns/1ps
module test_exec_count_brk;
  logic        clk = 1'b0;
  logic        rst;
  logic        cnt_en, match_i, wr_en;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        brk_o;

  always #2 clk = ~clk;

  exec_count_brk i_exec_count_brk (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .match_i(match_i),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .brk_o(brk_o)
  );

  typedef struct {
    logic        brk;
    logic [15:0] rd;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_vec = 0;
  int          n_bad = 0;
  logic [11:0] mcnt  = '0;
  bit          done  = 0;

  // driver: one vector per cycle, expectation pushed for the monitor
  task automatic apply(input bit m, input bit en, input bit w,
                       input logic [15:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    match_i = m; cnt_en = en; wr_en = w; wdata = d;
    e.brk = m && (!en || mcnt <= 12'd1);
    if (w)                          mcnt = d[11:0];
    else if (m && en && mcnt > 12'd1) mcnt = mcnt - 12'd1;
    e.rd  = {4'h0, mcnt};
    e.tag = tag;
    @(posedge clk);
    sb.push_back(e);
  endtask

  // monitor: compare once outputs settle after the edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_vec++;
      if (brk_o !== e.brk || rdata !== e.rd) begin
        n_bad++;
        $display("FAIL %s: brk=%0b rdata=%h expected brk=%0b rdata=%h",
                 e.tag, brk_o, rdata, e.brk, e.rd);
      end
    end
  end

  initial begin
    #600000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cnt_en = 0; match_i = 0; wr_en = 0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    n_vec++;
    if (brk_o !== 1'b0 || rdata !== 16'h0000) begin
      n_bad++;
      $display("FAIL R1: brk=%0b rdata=%h expected brk=0 rdata=0000", brk_o, rdata);
    end
    // R5 count zero with mode on
    apply(1, 1, 0, 16'h0, "R5");
    apply(0, 1, 0, 16'h0, "R8");
    // R2 write with upper bits set
    apply(0, 1, 1, 16'hF003, "R2");
    apply(0, 1, 0, 16'h0, "R2");
    // R3 decrements then R4 fire and hold
    apply(1, 1, 0, 16'h0, "R3");
    apply(1, 1, 0, 16'h0, "R3");
    apply(1, 1, 0, 16'h0, "R4");
    apply(1, 1, 0, 16'h0, "R4");
    apply(0, 1, 0, 16'h0, "R8");
    // R6 mode off leaves count
    apply(0, 1, 1, 16'h0005, "R2");
    apply(1, 0, 0, 16'h0, "R6");
    apply(1, 0, 0, 16'h0, "R6");
    apply(0, 0, 0, 16'h0, "R8");
    // R7 write collides with match above one, then at one
    apply(1, 1, 1, 16'h0009, "R7");
    apply(0, 1, 1, 16'h0001, "R2");
    apply(1, 1, 1, 16'h0007, "R7");
    apply(1, 1, 0, 16'h0, "R3");
    // R8 spaced matches give isolated pulses
    apply(0, 1, 1, 16'h0001, "R2");
    apply(1, 1, 0, 16'h0, "R8");
    apply(0, 1, 0, 16'h0, "R8");
    apply(1, 1, 0, 16'h0, "R8");
    apply(0, 1, 0, 16'h0, "R8");
    // R9 full-scale count
    apply(0, 1, 1, 16'hFFFF, "R9");
    for (int k = 0; k < 4094; k++) apply(1, 1, 0, 16'h0, "R9");
    apply(1, 1, 0, 16'h0, "R9");
    apply(0, 1, 0, 16'h0, "R9");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule